// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block is a purely combinational integer arithmetic stage for an execution pipe. It takes a destination operand, a source operand, an operand size (8, 16 or 32 bits), an opcode and the current carry flag. It returns the arithmetic result and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It also returns a write-enable mask that tells the surrounding flags register which of those six flags the operation is allowed to change.

A single adder serves all seven operations. Subtraction-type operations feed it the inverted source with a forced carry-in, so the sum is the two's complement difference. Their carry flag is then the inverted adder carry-out, which reads as a borrow. Only the bits of the selected size take part. Higher operand bits are ignored, and the result is zero above the selected size.

Top module: `int_alu_flags`

## Requirements
- R1: `size_i` selects the operand width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 and 2'b11 are 32 bits. Operand bits above the selected width do not affect any output, and `res_o` is zero above that width.
- R2: Opcodes 0 (add) and 1 (add with carry) give `res_o` = dst + src (+ `cf_i` for opcode 1), truncated to the width. `cf_o` is the carry out of the top bit of the width.
- R3: Opcodes 2 (subtract) and 3 (subtract with borrow) give `res_o` = dst − src (− `cf_i` for opcode 3), truncated to the width. `cf_o` is 1 exactly when the unsigned dst is smaller than src (+ `cf_i` for opcode 3).
- R4: `of_o` is 1 when the signed result does not fit the width: two same-sign addends give a different sign, or, for subtraction, the operands differ in sign and the result's sign differs from dst.
- R5: `af_o` is 1 on a carry out of bit 3 into bit 4 for add-type operations, and on a borrow into bit 3 for subtract-type operations.
- R6: `sf_o` equals the top bit of the result at the selected width. `zf_o` is 1 when the width-truncated result is zero. `pf_o` is 1 when bits 7:0 of the result hold an even number of ones.
- R7: Opcode 4 (increment) gives dst + 1 and opcode 5 (decrement) gives dst − 1. Both leave carry unwritten: `flag_we_o[0]` = 0 and `cf_o` = `cf_i`. OF, AF, SF, ZF and PF follow R4 to R6.
- R8: Opcode 6 (negate) gives 0 − dst, writes all six flags, and sets `cf_o` exactly when the width-truncated dst is nonzero.
- R9: `flag_we_o` bit order is {OF, SF, ZF, AF, PF, CF} from bit 5 down to bit 0. Opcodes 0–3 and 6 give 6'h3F and opcodes 4–5 give 6'h3E. Opcode 7 is reserved: the result, all flags and the mask are zero.
- R10: At 8 bits, 7Fh + 1 yields 80h with OF=1, SF=1, CF=0, and 26h − 95h yields 91h with CF=1, OF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| size_i | input | 2 | Operand width select |
| op_i | input | 3 | Operation code |
| cf_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Result, zero above the width |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| flag_we_o | output | 6 | Flag write-enable mask |

## Verification
The byte-size sweep covers every pair of operands for the four two-operand operations, with noise placed in the upper bits. A design that took its carry or sign from bit 31 instead of the selected width would show wrong flags on nearly every vector, and one that leaked upper bits would corrupt the result. Borrow polarity gets the most attention. A subtractor that forgot to invert the carry-out would report CF and AF reversed, and a borrow-with-carry operation that mishandled `cf_i` would be off by one when dst equals src. Increment and decrement are swept so that a design that wrote carry on them is caught through the mask and the pass-through value. Negate of zero is checked because a careless design sets carry there. Random 16- and 32-bit vectors confirm that the width select moves the carry, overflow and sign taps.

// File: rtl/int_alu_flags.sv
module int_alu_flags (
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  op_i,
  input  logic        cf_i,
  output logic [31:0] res_o,
  output logic        cf_o,
  output logic        pf_o,
  output logic        af_o,
  output logic        zf_o,
  output logic        sf_o,
  output logic        of_o,
  output logic [5:0]  flag_we_o
);

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBB = 3'd3;
  localparam logic [2:0] OP_INC = 3'd4;
  localparam logic [2:0] OP_DEC = 3'd5;
  localparam logic [2:0] OP_NEG = 3'd6;

  logic [31:0] mask;
  logic [31:0] opa, opb;
  logic        cin, is_sub, valid;
  logic [32:0] sum;
  logic [31:0] xr, res;
  logic        cout, cmsb, msb;

  always_comb begin
    case (size_i)
      2'b00:   mask = 32'h0000_00FF;
      2'b01:   mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    opa    = dst_i;
    opb    = src_i;
    cin    = 1'b0;
    is_sub = 1'b0;
    valid  = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin = cf_i;
      OP_SUB: begin opb = ~src_i; cin = 1'b1;   is_sub = 1'b1; end
      OP_SBB: begin opb = ~src_i; cin = ~cf_i;  is_sub = 1'b1; end
      OP_INC: begin opb = 32'd0;  cin = 1'b1; end
      OP_DEC: begin opb = ~32'd1; cin = 1'b1;   is_sub = 1'b1; end
      OP_NEG: begin opa = 32'd0;  opb = ~dst_i; cin = 1'b1; is_sub = 1'b1; end
      default: valid = 1'b0;
    endcase
  end

  assign sum = {1'b0, opa & mask} + {1'b0, opb & mask} + {32'd0, cin};
  assign res = sum[31:0] & mask;
  assign xr  = (opa & mask) ^ (opb & mask) ^ sum[31:0];

  always_comb begin
    case (size_i)
      2'b00:   begin cout = sum[8];  cmsb = xr[7];  msb = res[7];  end
      2'b01:   begin cout = sum[16]; cmsb = xr[15]; msb = res[15]; end
      default: begin cout = sum[32]; cmsb = xr[31]; msb = res[31]; end
    endcase
  end

  always_comb begin
    if (!valid)
      cf_o = 1'b0;
    else if (op_i == OP_INC || op_i == OP_DEC)
      cf_o = cf_i;
    else
      cf_o = cout ^ is_sub;
  end

  assign res_o     = valid ? res : 32'd0;
  assign of_o      = valid & (cout ^ cmsb);
  assign af_o      = valid & (xr[4] ^ is_sub);
  assign sf_o      = valid & msb;
  assign zf_o      = valid & (res == 32'd0);
  assign pf_o      = valid & ~(^res[7:0]);
  assign flag_we_o = !valid ? 6'h00 :
                     (op_i == OP_INC || op_i == OP_DEC) ? 6'h3E : 6'h3F;

endmodule

module int_alu_flags_chk (
  input logic [31:0] dst_i,
  input logic [1:0]  size_i,
  input logic [2:0]  op_i,
  input logic        cf_i,
  input logic [31:0] res_o,
  input logic        cf_o,
  input logic        pf_o,
  input logic        zf_o,
  input logic        sf_o,
  input logic [5:0]  flag_we_o
);
  logic [31:0] m;
  logic        top;
  assign m   = (size_i == 2'b00) ? 32'hFF : (size_i == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  assign top = (size_i == 2'b00) ? res_o[7] : (size_i == 2'b01) ? res_o[15] : res_o[31];

  always_comb begin
    // R1
    upper_zero_chk: assert ((res_o & ~m) == 32'd0);
    // R6
    sign_bit_chk: assert (op_i == 3'd7 || sf_o == top);
    // R6
    zero_flag_chk: assert (op_i == 3'd7 || zf_o == (res_o == 32'd0));
    // R6
    parity_chk: assert (op_i == 3'd7 || pf_o == ~(^res_o[7:0]));
    // R7
    carry_kept_chk: assert (!(op_i == 3'd4 || op_i == 3'd5) || (!flag_we_o[0] && cf_o == cf_i));
    // R8
    neg_carry_chk: assert (op_i != 3'd6 || cf_o == ((dst_i & m) != 32'd0));
    // R9
    reserved_chk: assert (op_i != 3'd7 || (flag_we_o == 6'd0 && res_o == 32'd0));
  end
endmodule

bind int_alu_flags int_alu_flags_chk u_chk (
  .dst_i(dst_i), .size_i(size_i), .op_i(op_i), .cf_i(cf_i), .res_o(res_o),
  .cf_o(cf_o), .pf_o(pf_o), .zf_o(zf_o), .sf_o(sf_o), .flag_we_o(flag_we_o)
);

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] dst, src, res;
  logic [1:0]  sz;
  logic [2:0]  op;
  logic        cfi, cf, pf, af, zf, sf, ovf;
  logic [5:0]  we;
  int total = 0, bad = 0;
  bit done = 0;

  int_alu_flags u0 (
    .dst_i(dst), .src_i(src), .size_i(sz), .op_i(op), .cf_i(cfi),
    .res_o(res), .cf_o(cf), .pf_o(pf), .af_o(af), .zf_o(zf), .sf_o(sf),
    .of_o(ovf), .flag_we_o(we)
  );

  task automatic chk(input string tag, input string what, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s op=%0d sz=%0d d=%h s=%h c=%0d act=%h exp=%h", tag, what, op, sz, dst, src, cfi, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] d, input logic [31:0] s, input logic [1:0] z,
                     input logic [2:0] o, input logic c, input string tag);
    int n;
    longint unsigned m, x, y, cc, full, r;
    bit sub, e_cf, e_of, e_af;
    logic [5:0] e_we;
    dst = d; src = s; sz = z; op = o; cfi = c;
    #2;
    n = (z == 2'b00) ? 8 : (z == 2'b01) ? 16 : 32;
    m = (64'd1 << n) - 1;
    x = d & m; y = s & m; cc = 0; sub = 0; e_we = 6'h3F;
    case (o)
      3'd1: cc = c;
      3'd2: sub = 1;
      3'd3: begin sub = 1; cc = c; end
      3'd4: begin y = 1; e_we = 6'h3E; end
      3'd5: begin y = 1; sub = 1; e_we = 6'h3E; end
      3'd6: begin y = x; x = 0; sub = 1; end
      default: ;
    endcase
    if (o == 3'd7) begin
      chk(tag, "res", res, 0);
      chk("R9", "we", we, 0);
      chk("R9", "flags", {cf, pf, af, zf, sf, ovf}, 0);
      return;
    end
    if (!sub) begin
      full = x + y + cc;
      e_cf = full[n];
      e_af = ((x & 15) + (y & 15) + cc) > 15;
    end else begin
      full = x - y - cc;
      e_cf = x < y + cc;
      e_af = (x & 15) < (y & 15) + cc;
    end
    r = full & m;
    if (!sub) e_of = (x[n-1] == y[n-1]) && (r[n-1] != x[n-1]);
    else      e_of = (x[n-1] != y[n-1]) && (r[n-1] != x[n-1]);
    if (o == 3'd4 || o == 3'd5) e_cf = c;
    chk(tag, "res", res, r);
    chk(tag, "cf", cf, e_cf);
    chk("R4", "of", ovf, e_of);
    chk("R5", "af", af, e_af);
    chk("R6", "sf/zf/pf", {sf, zf, pf}, {r[n-1], r == 0, ~(^r[7:0])});
    chk("R9", "we", we, e_we);
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R7";
      3'd6:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  initial begin
    #1900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    dst = 0; src = 0; sz = 0; op = 0; cfi = 0;
    #3;
    // reset-like idle state: add of zeros
    chk("R6", "idle zf", zf, 1);
    chk("R2", "idle res", res, 0);

    // R10 worked examples
    run(32'h7F, 32'h0, 2'b00, 3'd4, 1'b0, "R10");
    chk("R10", "inc 7F res", res, 32'h80);
    chk("R10", "inc 7F of/sf", {ovf, sf}, 2'b11);
    run(32'h7F, 32'h1, 2'b00, 3'd0, 1'b0, "R10");
    chk("R10", "add 7F+1 cf/of/sf", {cf, ovf, sf}, 3'b011);
    run(32'h26, 32'h95, 2'b00, 3'd2, 1'b0, "R10");
    chk("R10", "26-95", {res, cf, ovf}, {32'h91, 2'b11});

    // R8 negate of zero / R7 carry pass-through
    run(32'hFFFF_FF00, 0, 2'b00, 3'd6, 1'b1, "R8");
    chk("R8", "neg 0 cf", cf, 0);
    run(32'h0, 0, 2'b00, 3'd5, 1'b1, "R7");
    chk("R7", "dec 0 cf kept", cf, 1);

    // R1 upper bits ignored
    run(32'hDEAD_BEFF, 32'h1234_0001, 2'b00, 3'd0, 1'b0, "R1");
    chk("R1", "byte wrap upper zero", res, 32'h0);
    run(32'hABCD_FFFF, 32'h5555_0001, 2'b01, 3'd0, 1'b0, "R1");
    chk("R1", "word wrap", {res, cf}, {32'h0, 1'b1});
    run(32'hFFFF_FFFF, 32'h1, 2'b11, 3'd0, 1'b0, "R1");
    chk("R1", "dword sel 11", {res, cf}, {32'h0, 1'b1});

    // exhaustive byte sweep of two-operand ops with upper-bit noise
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++)
          run({8'hA5 ^ 8'(j), 16'h3C00 ^ 16'(i << 4), 8'(i)},
              {16'(i * 37), 8'h5A, 8'(j)}, 2'b00, 3'(o), 1'((i ^ j ^ (j >> 3)) & 1),
              (i == 0 && j == 0) ? "R1" : tag_of(3'(o)));

    // one-operand ops at byte size
    for (int o = 4; o < 8; o++)
      for (int i = 0; i < 256; i++)
        for (int c = 0; c < 2; c++)
          run({24'h9E3779, 8'(i)}, 32'hFFFF_FFFF, 2'b00, 3'(o), 1'(c), tag_of(3'(o)));

    // random word / dword vectors
    lf = 32'h1357_9BDF;
    for (int k = 0; k < 8000; k++) begin
      logic [31:0] a, b;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; a = lf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; b = lf;
      if (k % 7 == 0) b = a;
      run(a, b, 2'(1 + (k % 3)), 3'(k % 8), b[9], tag_of(3'(k % 8)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule